// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This controller sits between a word-organised CPU address bus and several banks of asynchronous DRAM. For each accepted request it splits the byte address into a bank index, a row and a column, and drives the multiplexed memory address, one active-low RAS line per bank and a shared active-low CAS line. The column field starts at address bit 1, because a DRAM word is two bytes wide. The width of the column field follows the DRAM density, and a five-bit configuration code selects that density.

The controller keeps the last row open after a CPU access. A later CPU access to the same bank and row then cycles only CAS. DMA cycles, bus-master cycles and refresh cycles always start from a closed page and leave the page closed, so the next CPU access must open its row again. Accesses to the top ROM window, and accesses that decode to a bank that is not fitted, are acknowledged without any DRAM activity. In the largest density, the RAS pin of the fourth bank carries memory address bit 10 instead.

A page miss while a row is open costs a precharge time, taken from the `pre_cycles` input. The row address is driven one cycle ahead of RAS, and the column address one cycle ahead of CAS. CAS is held for a fixed number of cycles, and `rdy` is returned in the last of them.

Top module: `dpc_ctrl`

## Requirements
- R1: `cfg_code` selects the density. Codes 17h to 19h select 4M-deep devices (column width 11). Codes 0Fh to 16h select 1M-deep devices (column width 10). Every other code selects 256K-deep devices (column width 9).
- R2: While CAS is asserted, the memory address carries the column, which is address bits 1 up to bit (column width) of the request.
- R3: When a bank's RAS falls, the memory address carries the row, which is the column-width bits directly above the column field. The same row value was already on the address lines in the cycle before.
- R4: A CPU access (`req_kind` 0) to the open bank and row keeps that RAS low throughout and asserts no new RAS edge. `rdy` comes 1+CAS_CYC cycles after the request edge.
- R5: A DMA access (`req_kind` 1) or a bus-master access (`req_kind` 2 or 3) precharges an open page first, even on a row match. When it completes, every bank RAS is high.
- R6: A refresh request closes an open page with a precharge, then asserts every available bank RAS with CAS high for CAS_CYC cycles, pulses `ref_ack` in the last of them, and leaves the page closed. Refresh takes priority over a simultaneous access request.
- R7: In the 4M densities, `ras_n[3]` carries memory address bit 10 and is never a bank strobe. Addresses below 800000h decode to bank 1, and addresses from 800000h upwards decode to bank 0.
- R8: An access at FC0000h or above gives `rom_sel` and `rdy` in the cycle after the request edge, starts no CAS, and leaves the open page, if any, untouched.
- R9: Latency from the request edge to `rdy` is 3+CAS_CYC cycles for a closed page and 3+CAS_CYC+P cycles for a page miss with a row open. P is `pre_cycles`, and a value of 0 counts as 1.
- R10: In the 256K and 1M densities, the bank index is the address shifted right by 2×(column width)+1. An index of NBANK or above is acknowledged with `rdy` in the next cycle, with no DRAM cycle.
- R11: CAS is asserted only while exactly one bank RAS is low. The address does not change on the cycle in which CAS falls. CAS stays low for CAS_CYC cycles, and `rdy` is asserted in the last of them.
- R12: During reset, every RAS and CAS is high and `rdy`, `rom_sel` and `ref_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_code | input | 5 | Memory configuration code (density select) |
| pre_cycles | input | PRE_W | Precharge length in cycles (0 counts as 1) |
| req | input | 1 | Access request, sampled only while idle |
| req_kind | input | 2 | 0 CPU, 1 DMA, 2 or 3 bus master |
| req_addr | input | 24 | Byte address of the access |
| ref_req | input | 1 | Refresh request, sampled only while idle |
| ma | output | 10 | Multiplexed memory address bits 9..0 |
| ras_n | output | NBANK | Per-bank row strobes; pin 3 is address bit 10 in 4M densities |
| cas_n | output | 1 | Column strobe |
| rdy | output | 1 | Access done |
| rom_sel | output | 1 | Access routed to the ROM window |
| ref_ack | output | 1 | Refresh done |

## Verification
The bound checker watches the cycle-level rules on every cycle:
- CAS appears only with a single RAS low.
- The address is steady at each RAS and CAS fall.
- A page hit and a ROM access leave the RAS lines unchanged.
- A DMA or bus-master cycle ends with all RAS high.
- No CAS appears during refresh.
- The shared pin is never a strobe in the 4M densities.

Only the bench's request sequences show the rest: the row and column values for each density, the bank decode on both sides of 800000h, the latencies for hit, miss and precharge lengths, and a page that stays open across a ROM access but not across DMA or refresh.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int ADDR_W     = 24;
  localparam int MA_FULL_W  = 11;
  localparam int BANK_IDX_W = 5;

  typedef enum logic [1:0] {DENS_256K = 2'd0, DENS_1M = 2'd1, DENS_4M = 2'd2} dens_e;

  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_ROW, S_RASA, S_COLS, S_CAS, S_RFR, S_QACK
  } st_e;

  // configuration code -> device density
  function automatic dens_e dens_of(input logic [4:0] code);
    if (code >= 5'h17 && code <= 5'h19) return DENS_4M;
    if (code >= 5'h0F && code <= 5'h16) return DENS_1M;
    return DENS_256K;
  endfunction

  // column field starts at bit 1 (word organised memory)
  function automatic logic [MA_FULL_W-1:0] col_of(input logic [ADDR_W-1:0] a, input dens_e d);
    case (d)
      DENS_4M: return a[11:1];
      DENS_1M: return {1'b0, a[10:1]};
      default: return {2'b00, a[9:1]};
    endcase
  endfunction

  // row field sits directly above the column field
  function automatic logic [MA_FULL_W-1:0] row_of(input logic [ADDR_W-1:0] a, input dens_e d);
    case (d)
      DENS_4M: return a[22:12];
      DENS_1M: return {1'b0, a[20:11]};
      default: return {2'b00, a[18:10]};
    endcase
  endfunction

  // bank index; the 4M layout puts the lower half on bank 1
  function automatic logic [BANK_IDX_W-1:0] bank_of(input logic [ADDR_W-1:0] a, input dens_e d);
    case (d)
      DENS_4M: return {4'b0000, ~a[23]};
      DENS_1M: return {2'b00, a[23:21]};
      default: return a[23:19];
    endcase
  endfunction
endpackage

// File: rtl/dpc_addr_split.sv
module dpc_addr_split
  import dpc_pkg::*;
#(
  parameter int                NBANK    = 4,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hFC0000
) (
  input  logic [ADDR_W-1:0]     addr,
  input  dens_e                 dens,
  output logic [MA_FULL_W-1:0]  row,
  output logic [MA_FULL_W-1:0]  col,
  output logic [BANK_IDX_W-1:0] bank,
  output logic                  present,
  output logic                  in_rom
);
  localparam logic [BANK_IDX_W:0] NB = (BANK_IDX_W+1)'(NBANK);

  assign row     = row_of(addr, dens);
  assign col     = col_of(addr, dens);
  assign bank    = bank_of(addr, dens);
  assign present = ({1'b0, bank} < NB);
  assign in_rom  = (addr >= ROM_BASE);
endmodule

// File: rtl/dpc_wait_cnt.sv
module dpc_wait_cnt #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= ld_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  // last cycle of a wait when the count is one (or zero)
  assign last = (cnt[W-1:1] == '0);
endmodule

// File: rtl/dpc_ref_row.sv
module dpc_ref_row #(
  parameter int W = 11
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] row
);
  always_ff @(posedge clk) begin
    if (!rst_n)    row <= '0;
    else if (step) row <= row + 1'b1;
  end
endmodule

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int                NBANK    = 4,
  parameter int                CAS_CYC  = 2,
  parameter int                PRE_W    = 3,
  parameter logic [ADDR_W-1:0] ROM_BASE = 24'hFC0000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4:0]            cfg_code,
  input  logic [PRE_W-1:0]      pre_cycles,
  input  logic                  req,
  input  logic [1:0]            req_kind,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic                  ref_req,
  output logic [MA_FULL_W-2:0]  ma,
  output logic [NBANK-1:0]      ras_n,
  output logic                  cas_n,
  output logic                  rdy,
  output logic                  rom_sel,
  output logic                  ref_ack
);
  localparam int MA10_PIN = 3;
  localparam int PRE_MAX  = (1 << PRE_W) - 1;
  localparam int CNT_MAX  = (CAS_CYC > PRE_MAX) ? CAS_CYC : PRE_MAX;
  localparam int CNT_W    = ($clog2(CNT_MAX + 1) < 2) ? 2 : $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] CAS_VAL = CNT_W'(CAS_CYC);

  st_e  st, st_nxt;
  dens_e dens;
  logic pg_open, lat_cpu, pre_to_ref, qrom;
  logic [MA_FULL_W-1:0]  lat_row, lat_col, sp_row, sp_col, ref_row, ma_full;
  logic [BANK_IDX_W-1:0] lat_bank, sp_bank;
  logic sp_present, sp_rom, cnt_last, ld;
  logic [CNT_W-1:0] ld_val, pre_val;
  logic [NBANK-1:0] ras_bank_n;

  assign dens    = dens_of(cfg_code);
  assign pre_val = (pre_cycles == '0) ? CNT_W'(1) : CNT_W'(pre_cycles);

  dpc_addr_split #(.NBANK(NBANK), .ROM_BASE(ROM_BASE)) u_split (
    .addr(req_addr), .dens(dens), .row(sp_row), .col(sp_col),
    .bank(sp_bank), .present(sp_present), .in_rom(sp_rom));

  // named events, also watched by the checker
  logic is_idle, take_ref, take_req, take_rom, take_nodev, take_dram, page_hit, take_hit;
  logic cas_done, ev_nocpu_end, in_ref, is_4m;
  assign is_idle      = (st == S_IDLE);
  assign take_ref     = is_idle && ref_req;
  assign take_req     = is_idle && !ref_req && req;
  assign take_rom     = take_req && sp_rom;
  assign take_nodev   = take_req && !sp_rom && !sp_present;
  assign take_dram    = take_req && !sp_rom && sp_present;
  assign page_hit     = pg_open && (req_kind == 2'd0) && (sp_bank == lat_bank) && (sp_row == lat_row);
  assign take_hit     = take_dram && page_hit;
  assign cas_done     = (st == S_CAS) && cnt_last;
  assign ev_nocpu_end = cas_done && !lat_cpu;
  assign in_ref       = (st == S_RFR);
  assign is_4m        = (dens == DENS_4M);

  dpc_wait_cnt #(.W(CNT_W)) u_wait (
    .clk(clk), .rst_n(rst_n), .load(ld), .ld_val(ld_val), .last(cnt_last));

  dpc_ref_row #(.W(MA_FULL_W)) u_rrow (
    .clk(clk), .rst_n(rst_n), .step(in_ref && cnt_last), .row(ref_row));

  always_comb begin
    st_nxt = st;
    ld     = 1'b0;
    ld_val = CAS_VAL;
    case (st)
      S_IDLE: begin
        if (take_ref) begin
          st_nxt = pg_open ? S_PRE : S_RFR;
          ld     = 1'b1;
          ld_val = pg_open ? pre_val : CAS_VAL;
        end else if (take_rom || take_nodev) begin
          st_nxt = S_QACK;
        end else if (take_dram) begin
          if (page_hit) st_nxt = S_COLS;
          else if (pg_open) begin
            st_nxt = S_PRE;
            ld     = 1'b1;
            ld_val = pre_val;
          end else st_nxt = S_ROW;
        end
      end
      S_PRE: if (cnt_last) begin
        st_nxt = pre_to_ref ? S_RFR : S_ROW;
        ld     = pre_to_ref;
      end
      S_ROW:  st_nxt = S_RASA;
      S_RASA: st_nxt = S_COLS;
      S_COLS: begin st_nxt = S_CAS; ld = 1'b1; end
      S_CAS:  if (cnt_last) st_nxt = S_IDLE;
      S_RFR:  if (cnt_last) st_nxt = S_IDLE;
      S_QACK: st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; pg_open <= 1'b0; lat_cpu <= 1'b0; pre_to_ref <= 1'b0; qrom <= 1'b0;
      lat_row <= '0; lat_col <= '0; lat_bank <= '0;
    end else begin
      st <= st_nxt;
      if (take_ref) begin
        pre_to_ref <= 1'b1;
        pg_open    <= 1'b0;
      end
      if (take_req) qrom <= sp_rom;
      if (take_dram) begin
        lat_row    <= sp_row;
        lat_col    <= sp_col;
        lat_bank   <= sp_bank;
        lat_cpu    <= (req_kind == 2'd0);
        pre_to_ref <= 1'b0;
        if (!page_hit) pg_open <= 1'b0;
      end
      if (cas_done) pg_open <= lat_cpu;
    end
  end

  // per-bank strobes before the shared pin is overlaid
  logic show_bank;
  assign show_bank = (st == S_RASA) || (st == S_COLS) || (st == S_CAS) ||
                     (((st == S_IDLE) || (st == S_QACK)) && pg_open);

  always_comb begin
    ras_bank_n = '1;
    for (int b = 0; b < NBANK; b++) begin
      if (show_bank && (lat_bank == BANK_IDX_W'(b))) ras_bank_n[b] = 1'b0;
      if (in_ref && !((b == MA10_PIN) && is_4m))      ras_bank_n[b] = 1'b0;
    end
  end

  always_comb begin
    case (st)
      S_ROW, S_RASA:  ma_full = lat_row;
      S_COLS, S_CAS:  ma_full = lat_col;
      S_RFR:          ma_full = ref_row;
      S_IDLE, S_QACK: ma_full = pg_open ? lat_col : '0;
      default:        ma_full = '0;
    endcase
  end

  assign ma = ma_full[MA_FULL_W-2:0];

  for (genvar g = 0; g < NBANK; g++) begin : g_pin
    if (g == MA10_PIN) begin : g_shared
      assign ras_n[g] = is_4m ? ma_full[MA_FULL_W-1] : ras_bank_n[g];
    end else begin : g_plain
      assign ras_n[g] = ras_bank_n[g];
    end
  end

  assign cas_n   = (st != S_CAS);
  assign rdy     = cas_done || (st == S_QACK);
  assign rom_sel = (st == S_QACK) && qrom;
  assign ref_ack = in_ref && cnt_last;
endmodule

// File: rtl/dpc_ctrl_chk.sv
module dpc_ctrl_chk #(
  parameter int NBANK     = 4,
  parameter int MA_FULL_W = 11
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cas_n,
  input logic                 rdy,
  input logic                 rom_sel,
  input logic                 take_rom,
  input logic                 take_hit,
  input logic                 ev_nocpu_end,
  input logic                 in_ref,
  input logic                 is_4m,
  input logic [NBANK-1:0]     ras_bank_n,
  input logic [MA_FULL_W-1:0] ma_full
);
  localparam int MA10_PIN = 3;

  a_r8_rom_no_dram: assert property (@(posedge clk) disable iff (!rst_n)
    take_rom |=> rom_sel && rdy && cas_n && $stable(ras_bank_n));

  a_r4_hit_keeps_row: assert property (@(posedge clk) disable iff (!rst_n)
    take_hit |=> $stable(ras_bank_n) && cas_n);

  a_r5_close_after_dma: assert property (@(posedge clk) disable iff (!rst_n)
    ev_nocpu_end |=> (&ras_bank_n));

  a_r11_cas_single_bank: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> ($countones(~ras_bank_n) == 1));

  a_r11_col_settled: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $stable(ma_full));

  a_r3_row_settled: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ref && $past(&ras_bank_n) && !(&ras_bank_n)) |-> (ma_full == $past(ma_full)));

  a_r6_refresh_no_cas: assert property (@(posedge clk) disable iff (!rst_n)
    in_ref |-> cas_n);

  if (NBANK > MA10_PIN) begin : g_r7
    a_r7_shared_pin_free: assert property (@(posedge clk) disable iff (!rst_n)
      is_4m |-> ras_bank_n[MA10_PIN]);
  end
endmodule

bind dpc_ctrl dpc_ctrl_chk #(.NBANK(NBANK), .MA_FULL_W(dpc_pkg::MA_FULL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cas_n(cas_n), .rdy(rdy), .rom_sel(rom_sel),
  .take_rom(take_rom), .take_hit(take_hit), .ev_nocpu_end(ev_nocpu_end),
  .in_ref(in_ref), .is_4m(is_4m), .ras_bank_n(ras_bank_n), .ma_full(ma_full));

// File: tb/tb_dpc_ctrl.sv
module tb_dpc_ctrl;
  localparam int CLK_NS = 10;
  localparam int PRE_W  = 3;
  localparam int NV     = 23;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [4:0] cfg_code = 5'h10;
  logic [PRE_W-1:0] pre_cycles = 3'd2;
  logic req = 1'b0, ref_req = 1'b0;
  logic [1:0] req_kind = 2'd0;
  logic [23:0] req_addr = '0;
  logic [9:0] ma;
  logic [3:0] ras_n;
  logic cas_n, rdy, rom_sel, ref_ack;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #(CLK_NS/2) clk = ~clk;

  dpc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_code(cfg_code), .pre_cycles(pre_cycles),
    .req(req), .req_kind(req_kind), .req_addr(req_addr), .ref_req(ref_req),
    .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .rdy(rdy), .rom_sel(rom_sel), .ref_ack(ref_ack));

  // kind 3 in the table means a refresh request
  typedef struct packed {
    logic [4:0]  cfg;
    logic [1:0]  kind;
    logic [23:0] addr;
    logic [7:0]  lat;
    logic        dram;
    logic        hit;
    logic        rom;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{5'h10, 2'd0, 24'h012344, 8'd5, 1'b1, 1'b0, 1'b0},
    '{5'h10, 2'd0, 24'h012346, 8'd3, 1'b1, 1'b1, 1'b0},
    '{5'h10, 2'd0, 24'h012800, 8'd7, 1'b1, 1'b0, 1'b0},
    '{5'h10, 2'd1, 24'h012802, 8'd7, 1'b1, 1'b0, 1'b0},
    '{5'h10, 2'd0, 24'h012804, 8'd5, 1'b1, 1'b0, 1'b0},
    '{5'h10, 2'd0, 24'hFC0010, 8'd1, 1'b0, 1'b0, 1'b1},
    '{5'h10, 2'd0, 24'h012806, 8'd3, 1'b1, 1'b1, 1'b0},
    '{5'h10, 2'd2, 24'h400000, 8'd7, 1'b1, 1'b0, 1'b0},
    '{5'h10, 2'd0, 24'h900000, 8'd1, 1'b0, 1'b0, 1'b0},
    '{5'h19, 2'd0, 24'h812346, 8'd5, 1'b1, 1'b0, 1'b0},
    '{5'h19, 2'd0, 24'h7FF800, 8'd7, 1'b1, 1'b0, 1'b0},
    '{5'h19, 2'd0, 24'h7FFFFE, 8'd3, 1'b1, 1'b1, 1'b0},
    '{5'h19, 2'd0, 24'hFFFFFE, 8'd1, 1'b0, 1'b0, 1'b1},
    '{5'h19, 2'd3, 24'h000000, 8'd4, 1'b0, 1'b0, 1'b0},
    '{5'h02, 2'd0, 24'h0403FE, 8'd5, 1'b1, 1'b0, 1'b0},
    '{5'h02, 2'd0, 24'h0403FC, 8'd3, 1'b1, 1'b1, 1'b0},
    '{5'h02, 2'd0, 24'h180000, 8'd7, 1'b1, 1'b0, 1'b0},
    '{5'h02, 2'd0, 24'h200000, 8'd1, 1'b0, 1'b0, 1'b0},
    '{5'h02, 2'd3, 24'h000000, 8'd4, 1'b0, 1'b0, 1'b0},
    '{5'h17, 2'd0, 24'h000002, 8'd5, 1'b1, 1'b0, 1'b0},
    '{5'h17, 2'd1, 24'h000004, 8'd7, 1'b1, 1'b0, 1'b0},
    '{5'h16, 2'd3, 24'h000000, 8'd2, 1'b0, 1'b0, 1'b0},
    '{5'h16, 2'd0, 24'h012344, 8'd5, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  // R1: the bench's own density decode, as column width
  function automatic int col_w(input logic [4:0] c);
    if (c >= 5'h17 && c <= 5'h19) return 11;
    if (c >= 5'h0F && c <= 5'h16) return 10;
    return 9;
  endfunction

  function automatic logic [3:0] obs_bank();
    return (col_w(cfg_code) == 11) ? (ras_n | 4'b1000) : ras_n;
  endfunction

  function automatic logic [10:0] obs_ma();
    return {(col_w(cfg_code) == 11) ? ras_n[3] : 1'b0, ma};
  endfunction

  task automatic run_vec(input vec_t v, input logic [PRE_W-1:0] pre, input string tag);
    int cw, eb, k;
    logic [10:0] er, ec, row_seen, col_seen;
    logic [3:0] prev, cur, pat;
    logic prev_cas, got, fell, rose, cfell, saw_rom;
    cfg_code   = v.cfg;
    pre_cycles = pre;
    cw = col_w(v.cfg);
    ec = 11'((v.addr >> 1) & ((24'd1 << cw) - 1));
    er = 11'((v.addr >> (cw + 1)) & ((24'd1 << cw) - 1));
    eb = (cw == 11) ? ((v.addr < 24'h800000) ? 1 : 0) : int'(v.addr >> (2 * cw + 1));
    #1;
    prev = obs_bank(); prev_cas = cas_n;
    if (v.kind == 2'd3) ref_req = 1'b1;
    else begin req = 1'b1; req_kind = v.kind; req_addr = v.addr; end
    @(negedge clk);
    req = 1'b0; ref_req = 1'b0;
    got = 0; fell = 0; rose = 0; cfell = 0; saw_rom = 0; k = 1;
    row_seen = '0; col_seen = '0; pat = '1;
    while (!got && k <= 40) begin
      cur = obs_bank();
      if ((&prev) && !(&cur) && !fell) begin fell = 1; row_seen = obs_ma(); pat = cur; end
      if (!(&prev) && (&cur)) rose = 1;
      if (prev_cas && !cas_n && !cfell) begin cfell = 1; col_seen = obs_ma(); end
      if ((v.kind == 2'd3) ? ref_ack : rdy) begin got = 1; saw_rom = rom_sel; end
      prev = cur; prev_cas = cas_n;
      if (!got) begin @(negedge clk); k++; end
    end
    chk(got && (k == int'(v.lat)), {tag, " R9/R4 latency"}, 32'(k), 32'(v.lat));
    if (v.dram && !v.hit) begin
      chk(fell && (row_seen == er), {tag, " R3 row at RAS fall"}, 32'(row_seen), 32'(er));
      chk(pat == ~(4'b0001 << eb), {tag, " R10/R7 bank strobe"}, 32'(pat), 32'(~(4'b0001 << eb)));
    end
    if (v.hit) chk(!fell && !rose, {tag, " R4 RAS held on hit"}, 32'({fell, rose}), 32'(0));
    if (v.dram) chk(cfell && (col_seen == ec), {tag, " R2 column at CAS fall"}, 32'(col_seen), 32'(ec));
    else chk(!cfell, {tag, " R8/R10/R6 no CAS"}, 32'(cfell), 32'(0));
    if (v.kind != 2'd3) chk(saw_rom == v.rom, {tag, " R8 rom_sel"}, 32'(saw_rom), 32'(v.rom));
    if (v.kind == 2'd3)
      chk(fell && (pat == ((cw == 11) ? 4'b1000 : 4'b0000)), {tag, " R6 refresh strobes"},
          32'(pat), 32'((cw == 11) ? 4'b1000 : 4'b0000));
    @(negedge clk);
    cur = obs_bank();
    if (v.dram && v.kind == 2'd0)
      chk(cur == ~(4'b0001 << eb), {tag, " R4 page left open"}, 32'(cur), 32'(~(4'b0001 << eb)));
    else if (v.dram || v.kind == 2'd3)
      chk(cur == 4'b1111, {tag, " R5/R6 page closed"}, 32'(cur), 32'hF);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n == 4'hF && cas_n && !rdy && !rom_sel && !ref_ack, "R12 reset outputs",
        32'({ras_n, cas_n, rdy, rom_sel, ref_ack}), 32'({4'hF, 1'b1, 3'b000}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(ras_n == 4'hF && cas_n && !rdy, "R12 idle after reset", 32'({ras_n, cas_n, rdy}), 32'({4'hF, 1'b1, 1'b0}));

    for (int i = 0; i < NV; i++) run_vec(VECS[i], 3'd2, $sformatf("vec%0d", i));

    // R9: longer precharge, then a zero setting that counts as one cycle
    run_vec('{5'h10, 2'd0, 24'h400000, 8'd8, 1'b1, 1'b0, 1'b0}, 3'd3, "r9_pre3");
    run_vec('{5'h10, 2'd0, 24'h012344, 8'd6, 1'b1, 1'b0, 1'b0}, 3'd0, "r9_pre0");
    // R5: DMA to the open row still precharges, then closes
    run_vec('{5'h10, 2'd1, 24'h012344, 8'd6, 1'b1, 1'b0, 1'b0}, 3'd0, "r5_dma_same_row");
    // R7: lowest address of bank 0 in a 4M layout
    run_vec('{5'h18, 2'd0, 24'h800000, 8'd5, 1'b1, 1'b0, 1'b0}, 3'd2, "r7_bank0_base");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule